// File: doc/BRIEF.md
# Set-Associative LRU Tag Hit Detector

This block keeps cache tags and no data. For every memory reference it reports whether the reference would hit or miss in a set-associative, write-allocate cache with least-recently-used replacement. A reference is a byte address plus a byte count. The block works out which line-sized block or blocks the reference covers. It looks each one up in its set, reorders that set by recency, and returns one hit or miss result for the reference as a whole.

Each set is kept as an ordered list of entries. The most recently used entry sits in slot 0, and older entries are pushed toward the last slot. The stored tag is the complete block number. Index bits are not stripped from it. A reference that crosses one line boundary is treated as a single access that touches two sets. It takes two internal cycles, and the block lowers `req_ready` for the second one. A reference covering more than two blocks is rejected with an error flag.

Top module: `lru_tag_detector`

## Requirements
- R1: The number of sets is CACHE_BYTES / LINE_BYTES / WAYS. The block number is the address shifted right by log2(LINE_BYTES). The set index is the low log2(sets) bits of the block number. The tag is the full block number, so two blocks with the same index but different block numbers never hit on each other, and blocks with different indices never evict each other.
- R2: A synchronous active-high reset empties every set and clears the response outputs, with `req_ready` high. The first reference after reset misses, including one to block number 0.
- R3: A hit on the most recently used entry of a set leaves the order of that set unchanged.
- R4: A hit on the entry in recency slot i > 0 moves that entry to slot 0. Slots 0..i-1 each move down by one, and slots after i keep their place.
- R5: A miss inserts the block at slot 0 and moves every other entry down one slot. When the set already holds WAYS blocks, the least recently used block is dropped. Reads and writes are not distinguished: every miss allocates.
- R6: The last byte of a reference is at addr + size - 1, with size 0 treated as 1. When the first and last bytes lie in the same block, one lookup is made. `resp_valid` is then high for one cycle, on the cycle after the request is accepted, and `req_ready` stays high.
- R7: When the last byte lies in the block after the first, both blocks are looked up and both sets are updated, whatever the outcome of the first lookup. `req_ready` is low on the cycle after acceptance. `resp_valid` rises one cycle later, with `resp_miss` high unless both lookups hit.
- R8: A reference whose last byte lies neither in the first block nor in the next one is illegal. One cycle after acceptance it produces `resp_valid` with `resp_error` high and `resp_miss` low, and no set changes.
- R9: A request is accepted only when `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low is ignored and does not touch any set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A reference is presented |
| req_ready | output | 1 | Block can accept a reference this cycle |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Byte count of the reference (0 read as 1) |
| resp_valid | output | 1 | Result of one reference is present |
| resp_miss | output | 1 | Reference missed (valid with resp_valid) |
| resp_error | output | 1 | Reference covered more than two blocks |

## Verification
A result for a one-block reference or an illegal reference is due exactly one clock after the accepting edge. A two-block reference shows `req_ready` low and no result one clock after acceptance, and its result one clock after that. The bench drives each request on a falling edge and recomputes the recency lists in a queue-based model at the following falling edge. It compares `resp_valid`, `resp_miss`, `resp_error` and `req_ready` there, and checks that no result appears on idle cycles. To test R9, a request is held on the input during the busy cycle, and the bench later shows that the held block still misses.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        REF_ONE = 2'd0,
        REF_TWO = 2'd1,
        REF_BAD = 2'd2
    } ref_kind_e;

    // distance from first to last byte; a zero count is read as one byte
    function automatic int unsigned span_m1(input int unsigned sz);
        return (sz == 0) ? 0 : sz - 1;
    endfunction

endpackage

// File: rtl/addr_splitter.sv
module addr_splitter
    import lru_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 6,
    parameter int OFS_W  = 4,
    localparam int BLK_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [BLK_W-1:0]  blk_first,
    output logic [BLK_W-1:0]  blk_last,
    output ref_kind_e         kind
);
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        last_byte = addr + ADDR_W'(span_m1(32'(size)));
        blk_first = addr[ADDR_W-1:OFS_W];
        blk_last  = last_byte[ADDR_W-1:OFS_W];
        if (blk_last == blk_first)
            kind = REF_ONE;
        else if (blk_last == blk_first + BLK_W'(1))
            kind = REF_TWO;
        else
            kind = REF_BAD;
    end
endmodule

// File: rtl/lru_set_update.sv
module lru_set_update #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 28
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0][TAG_W-1:0]  old_tags,
    input  logic [WAYS-1:0]             old_vld,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAYS-1:0][TAG_W-1:0]  new_tags,
    output logic [WAYS-1:0]             new_vld
);
    logic [WAYS-1:0] match;
    int              pos;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = old_vld[w] && (old_tags[w] == tag);
    end

    always_comb begin
        hit = |match;
        // a miss shifts the whole list, like a hit in the last slot
        pos = WAYS - 1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) pos = w;
        end
        for (int w = 0; w < WAYS; w++) begin
            if (w == 0) begin
                new_tags[w] = tag;
                new_vld[w]  = 1'b1;
            end else if (w <= pos) begin
                new_tags[w] = old_tags[w-1];
                new_vld[w]  = old_vld[w-1];
            end else begin
                new_tags[w] = old_tags[w];
                new_vld[w]  = old_vld[w];
            end
        end
    end

    // R4
    unique_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/tag_store.sv
module tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 28,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_vld,
    input  logic                        wr_en,
    input  logic [WAYS-1:0][TAG_W-1:0]  wr_tags,
    input  logic [WAYS-1:0]             wr_vld
);
    logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
    logic [WAYS-1:0]            vld_mem [SETS];

    assign rd_tags = tag_mem[idx];
    assign rd_vld  = vld_mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tag_mem[s] <= '0;
                vld_mem[s] <= '0;
            end
        end else if (wr_en) begin
            tag_mem[idx] <= wr_tags;
            vld_mem[idx] <= wr_vld;
        end
    end
endmodule

// File: rtl/lru_tag_detector.sv
module lru_tag_detector
    import lru_tag_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 6,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              resp_valid,
    output logic              resp_miss,
    output logic              resp_error
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int BLK_W = ADDR_W - OFS_W;

    ctl_state_e          state_q;
    logic [BLK_W-1:0]    pend_blk_q;
    logic                first_miss_q;
    logic                rv_q, rm_q, re_q;

    logic [BLK_W-1:0]    blk_first, blk_last, look_blk;
    ref_kind_e           kind;
    logic                accept, look_en, hit;
    logic [IDX_W-1:0]    idx;

    logic [WAYS-1:0][BLK_W-1:0] cur_tags, nxt_tags;
    logic [WAYS-1:0]            cur_vld, nxt_vld;

    addr_splitter #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)) u_split (
        .addr      (req_addr),
        .size      (req_size),
        .blk_first (blk_first),
        .blk_last  (blk_last),
        .kind      (kind)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign look_blk  = (state_q == ST_SECOND) ? pend_blk_q : blk_first;
    assign look_en   = (state_q == ST_SECOND) || (accept && kind != REF_BAD);

    if (SETS > 1) begin : g_idx_sel
        assign idx = look_blk[IDX_W-1:0];
    end else begin : g_idx_one
        assign idx = '0;
    end

    tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(BLK_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .rd_tags (cur_tags),
        .rd_vld  (cur_vld),
        .wr_en   (look_en),
        .wr_tags (nxt_tags),
        .wr_vld  (nxt_vld)
    );

    lru_set_update #(.WAYS(WAYS), .TAG_W(BLK_W)) u_upd (
        .clk      (clk),
        .rst      (rst),
        .old_tags (cur_tags),
        .old_vld  (cur_vld),
        .tag      (look_blk),
        .hit      (hit),
        .new_tags (nxt_tags),
        .new_vld  (nxt_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pend_blk_q   <= '0;
            first_miss_q <= 1'b0;
            rv_q         <= 1'b0;
            rm_q         <= 1'b0;
            re_q         <= 1'b0;
        end else begin
            rv_q <= 1'b0;
            rm_q <= 1'b0;
            re_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (kind)
                            REF_ONE: begin
                                rv_q <= 1'b1;
                                rm_q <= !hit;
                            end
                            REF_TWO: begin
                                state_q      <= ST_SECOND;
                                pend_blk_q   <= blk_last;
                                first_miss_q <= !hit;
                            end
                            default: begin
                                rv_q <= 1'b1;
                                re_q <= 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    rv_q    <= 1'b1;
                    rm_q    <= first_miss_q || !hit;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign resp_valid = rv_q;
    assign resp_miss  = rm_q;
    assign resp_error = re_q;

    // R6
    single_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == REF_ONE) |=> (resp_valid && req_ready && !resp_error));

    // R7
    straddle_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == REF_TWO) |=> (!req_ready && !resp_valid));

    // R7
    straddle_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SECOND) |=> (resp_valid && req_ready));

    // R8
    bad_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == REF_BAD) |=> (resp_valid && resp_error && !resp_miss));
endmodule

// File: tb/lru_tag_detector_test.sv
module lru_tag_detector_test;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 6;
    localparam int CBYTES = 1024;
    localparam int WAYS   = 4;
    localparam int LINE   = 16;
    localparam int NSETS  = CBYTES / LINE / WAYS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              resp_valid, resp_miss, resp_error;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int unsigned lists [NSETS][$];

    always #4 clk = ~clk;

    lru_tag_detector #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CACHE_BYTES(CBYTES),
        .WAYS(WAYS), .LINE_BYTES(LINE)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .resp_valid(resp_valid),
        .resp_miss(resp_miss), .resp_error(resp_error)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", rq, what, act, exp);
        end
    endtask

    // behavioural recency model: front of queue is most recent
    function automatic bit touch(input int unsigned blk);
        int unsigned s = blk % NSETS;
        for (int i = 0; i < lists[s].size(); i++) begin
            if (lists[s][i] == blk) begin
                lists[s].delete(i);
                lists[s].push_front(blk);
                return 1'b0;
            end
        end
        lists[s].push_front(blk);
        if (lists[s].size() > WAYS) void'(lists[s].pop_back());
        return 1'b1;
    endfunction

    task automatic idle_check(input string rq);
        @(negedge clk);
        chk(rq, "idle resp_valid", resp_valid, 1'b0);
        chk(rq, "idle req_ready", req_ready, 1'b1);
    endtask

    task automatic issue(input int unsigned a, input int unsigned sz, input string rq,
                         input bit hold = 1'b0, input int unsigned ha = 0);
        int unsigned eff, b1, b2;
        bit m1, m2;
        @(negedge clk);
        chk("R9", "ready before request", req_ready, 1'b1);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = SIZE_W'(sz);
        eff = (sz == 0) ? 1 : sz;
        b1  = a / LINE;
        b2  = (a + eff - 1) / LINE;
        @(negedge clk);
        if (b2 == b1) begin
            req_valid = 1'b0;
            m1 = touch(b1);
            chk("R6", "resp_valid", resp_valid, 1'b1);
            chk("R6", "req_ready", req_ready, 1'b1);
            chk(rq, "resp_miss", resp_miss, m1);
            chk("R6", "resp_error", resp_error, 1'b0);
        end else if (b2 == b1 + 1) begin
            m1 = touch(b1);
            m2 = touch(b2);
            chk("R7", "busy req_ready", req_ready, 1'b0);
            chk("R7", "busy resp_valid", resp_valid, 1'b0);
            if (hold) begin
                req_addr = ha;
                req_size = SIZE_W'(1);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R7", "resp_valid", resp_valid, 1'b1);
            chk("R7", "req_ready", req_ready, 1'b1);
            chk(rq, "resp_miss", resp_miss, m1 | m2);
            chk("R7", "resp_error", resp_error, 1'b0);
        end else begin
            req_valid = 1'b0;
            chk("R8", "resp_valid", resp_valid, 1'b1);
            chk("R8", "resp_error", resp_error, 1'b1);
            chk("R8", "resp_miss", resp_miss, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2", "reset resp_valid", resp_valid, 1'b0);
        rst = 1'b0;
        idle_check("R2");

        // R2: block 0 misses after reset, then R3 repeats hit in MRU slot
        issue(32'h000, 4, "R2");
        issue(32'h004, 4, "R3");
        issue(32'h008, 1, "R3");
        // R5: fill set 0
        issue(32'h100, 4, "R5");
        issue(32'h200, 4, "R5");
        issue(32'h300, 4, "R5");
        // R4: promote block 0 from the last slot
        issue(32'h000, 2, "R4");
        // R5: new block evicts the least recent (block 16)
        issue(32'h400, 2, "R5");
        issue(32'h100, 2, "R5");
        issue(32'h300, 2, "R4");
        issue(32'h200, 2, "R5");
        // R1: same index, different block numbers; other index untouched
        issue(32'h010, 4, "R1");
        issue(32'h110, 4, "R1");
        issue(32'h010, 4, "R1");
        issue(32'h300, 4, "R1");
        idle_check("R6");
        // R7: straddles, both missing, then both hitting, then mixed
        issue(32'h02E, 4, "R7");
        issue(32'h02E, 4, "R7");
        issue(32'h03E, 4, "R7");
        issue(32'h040, 1, "R7");
        issue(32'h05E, 4, "R7");
        issue(32'h060, 1, "R7");
        // R8: spans three blocks, no update
        issue(32'h070, 40, "R8");
        issue(32'h070, 1, "R8");
        issue(32'h080, 40, "R8");
        issue(32'h080, 1, "R8");
        // R6: zero size is one byte, so no straddle
        issue(32'h090, 0, "R6");
        // R9: request held during busy cycle is ignored
        issue(32'h0AE, 4, "R7", 1'b1, 32'h0C0);
        idle_check("R9");
        issue(32'h0C0, 1, "R9");

        for (int n = 0; n < 600; n++) begin
            int unsigned ra = $urandom_range(0, 32'h3FF);
            int unsigned rs = ($urandom_range(0, 15) == 0) ? 40 : $urandom_range(0, 8);
            issue(ra, rs, "R5");
            if ($urandom_range(0, 3) == 0) idle_check("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule